// File: doc/BRIEF.md
# Delayed single-shot pulse timer

This block is a down-counting timer that, once started, waits for a programmed delay and then drives one output pulse of programmed width. After the pulse it stops without help from software. A host writes a start count, a reload (width) value and a control word through a small register port. The timer then advances by one on each cycle in which the count-clock strobe is high. An external start input can also launch an idle timer.

The run has two phases. The delay phase counts down from the start count. At its underflow the output flip-flop inverts, and the counter is reloaded from the width value one tick later. It then counts down through the pulse phase. At the second underflow the output inverts again and the enable bit clears. Each underflow can raise a one-cycle interrupt request. Fixed rules decide the winner when the self-stop, an external start and a software write to the enable bit fall in the same cycle.

The 24-bit count is held as a 16-bit low part and an 8-bit high part, with a borrow between them. The host can read it at any time.

Top module: `delay_pulse_timer`

## Requirements
- R1: After reset, reads of the counter (address 0), the reload register (address 1) and the control word (address 2) return 0, and `pulse_out` and `irq_o` are low.
- R2: Once the enable bit is set, the first underflow falls on the (C+1)-th count tick, where C is the counter value. `irq_o` is high in the clock cycle that follows that tick's edge.
- R3: The second underflow falls R+1 count ticks after the first, where R is the reload value.
- R4: After the second underflow, the enable bit (control bit 0) reads 0 and the counter reads 0xFFFFFF and no longer changes.
- R5: `pulse_out` inverts at each of the two underflows. Its level before the run is taken from control bit 2 when the control word is written while the timer is stopped.
- R6: `irq_o` is high for one cycle after each underflow only when control bit 1 is set. With that bit clear it stays low, while `pulse_out` still toggles.
- R7: In the cycle after the first underflow the counter reads 0xFFFFFF. After the next count tick it reads the reload value minus 1.
- R8: A pulse on `ext_start` enables an idle timer. If it falls in the cycle of the second underflow, the stop wins and the enable bit reads 0.
- R9: A control write that sets bit 0 in the cycle of the second underflow wins, and the timer stays enabled and keeps counting down from 0xFFFFFF.
- R10: A control write that clears bit 0 in the same cycle as an `ext_start` pulse wins, and the timer stays stopped with its counter unchanged.
- R11: When the low 16 bits are zero, a count tick takes the counter from 0x010000 to 0x00FFFF.
- R12: While the timer runs, a reload write updates the register readback but not the width of the current pulse, and a counter write is ignored.
- R13: A reload value of 0 gives a pulse one count tick wide.
- R14: In cycles without a count tick, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_tick | input | 1 | Count-clock strobe; one count step per cycle it is high |
| ext_start | input | 1 | External start pulse |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address: 0 counter, 1 reload, 2 control |
| host_wdata | input | 24 | Write data |
| host_rdata | output | 24 | Read data for `host_addr` (combinational) |
| pulse_out | output | 1 | Output flip-flop |
| irq_o | output | 1 | Interrupt request, one cycle per enabled underflow |

## Verification
The enable bit is the contested resource. In one cycle it can receive the self-stop at the second underflow, an external start and a host control write. The bench times `ext_start` or a control write to the negedge just before the edge that carries the second underflow, which it computes from the programmed count and reload values. It then also drives a start and a clearing write together on an idle timer. Each outcome is judged by reading back the enable bit and the counter over the following cycles, and by whether further interrupt requests appear.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  typedef enum logic [1:0] {
    ADDR_CNT  = 2'd0,
    ADDR_RLD  = 2'd1,
    ADDR_CTRL = 2'd2
  } reg_addr_e;

  typedef enum logic {
    PH_DELAY = 1'b0,
    PH_PULSE = 1'b1
  } phase_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_IRQEN_BIT = 1;
  localparam int CTRL_LVL_BIT   = 2;

endpackage

// File: rtl/dpt_split_cnt.sv
module dpt_split_cnt #(
  parameter int LO_W = 16,
  parameter int HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [LO_W+HI_W-1:0] ld_val,
  input  logic                 dec,
  output logic [LO_W+HI_W-1:0] cnt,
  output logic                 zero
);
  localparam int W = LO_W + HI_W;

  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            lo_borrow;

  assign lo_borrow = (lo_q == '0);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (ld) begin
      lo_d = ld_val[LO_W-1:0];
      hi_d = ld_val[W-1:LO_W];
    end else if (dec) begin
      lo_d = lo_q - {{(LO_W-1){1'b0}}, 1'b1};
      if (lo_borrow) begin
        hi_d = hi_q - {{(HI_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ld || dec) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt  = {hi_q, lo_q};
  assign zero = lo_borrow && (hi_q == '0);

endmodule

// File: rtl/dpt_regs.sv
module dpt_regs
  import dpt_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_wr,
  input  logic [1:0]   host_addr,
  input  logic [W-1:0] host_wdata,
  input  logic         ext_start,
  input  logic         seq_stop,
  input  logic [W-1:0] cnt_val,
  input  logic         lvl_q,
  output logic         en_q,
  output logic         irq_en_q,
  output logic [W-1:0] reload_q,
  output logic         en_rise,
  output logic         host_cnt_ld,
  output logic         lvl_ld,
  output logic         lvl_val,
  output logic [W-1:0] host_rdata
);
  logic         ctrl_wr, rld_wr;
  logic         en_d, irq_en_d;
  logic [W-1:0] reload_d;

  assign ctrl_wr = host_wr && (host_addr == ADDR_CTRL);
  assign rld_wr  = host_wr && (host_addr == ADDR_RLD);

  // Enable priority: host write, then self-stop, then external start.
  always_comb begin
    en_d = en_q;
    if (ctrl_wr)        en_d = host_wdata[CTRL_EN_BIT];
    else if (seq_stop)  en_d = 1'b0;
    else if (ext_start) en_d = 1'b1;
  end

  assign irq_en_d = ctrl_wr ? host_wdata[CTRL_IRQEN_BIT] : irq_en_q;
  assign reload_d = rld_wr ? host_wdata : reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      reload_q <= '0;
    end else begin
      en_q <= en_d;
      if (ctrl_wr) irq_en_q <= irq_en_d;
      if (rld_wr)  reload_q <= reload_d;
    end
  end

  assign en_rise     = en_d && !en_q;
  assign host_cnt_ld = host_wr && (host_addr == ADDR_CNT) && !en_q;
  assign lvl_ld      = ctrl_wr && !en_q;
  assign lvl_val     = host_wdata[CTRL_LVL_BIT];

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADDR_CNT:  host_rdata = cnt_val;
      ADDR_RLD:  host_rdata = reload_q;
      ADDR_CTRL: begin
        host_rdata[CTRL_EN_BIT]    = en_q;
        host_rdata[CTRL_IRQEN_BIT] = irq_en_q;
        host_rdata[CTRL_LVL_BIT]   = lvl_q;
      end
      default:   host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dpt_seq.sv
module dpt_seq
  import dpt_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en_q,
  input  logic         en_rise,
  input  logic         cnt_zero,
  input  logic [W-1:0] reload_q,
  input  logic         irq_en_q,
  input  logic         lvl_ld,
  input  logic         lvl_val,
  output logic         seq_ld,
  output logic [W-1:0] seq_ld_val,
  output logic         seq_dec,
  output logic         uf_first,
  output logic         uf_last,
  output logic         out_q,
  output logic         irq_q
);
  phase_e       ph_q, ph_d;
  logic         pend_q, pend_d;
  logic [W-1:0] cap_q, cap_d;
  logic         out_d, irq_d, act, uf;

  assign act = tick && en_q;

  always_comb begin
    ph_d       = ph_q;
    pend_d     = pend_q;
    cap_d      = cap_q;
    seq_ld     = 1'b0;
    seq_ld_val = '0;
    seq_dec    = 1'b0;
    uf_first   = 1'b0;
    uf_last    = 1'b0;
    if (en_rise) begin
      ph_d   = PH_DELAY;
      pend_d = 1'b0;
    end else if (act) begin
      if (pend_q) begin
        // deferred reload: the tick after the first underflow
        pend_d = 1'b0;
        seq_ld = 1'b1;
        if (cap_q == '0) begin
          uf_last    = 1'b1;
          seq_ld_val = '1;
          ph_d       = PH_DELAY;
        end else begin
          seq_ld_val = cap_q - {{(W-1){1'b0}}, 1'b1};
        end
      end else if (cnt_zero) begin
        seq_dec = 1'b1;
        if (ph_q == PH_DELAY) begin
          uf_first = 1'b1;
          pend_d   = 1'b1;
          cap_d    = reload_q;
          ph_d     = PH_PULSE;
        end else begin
          uf_last = 1'b1;
          ph_d    = PH_DELAY;
        end
      end else begin
        seq_dec = 1'b1;
      end
    end
  end

  assign uf    = uf_first || uf_last;
  assign out_d = lvl_ld ? lvl_val : (uf ? !out_q : out_q);
  assign irq_d = uf && irq_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_DELAY;
      pend_q <= 1'b0;
      cap_q  <= '0;
      out_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pend_q <= pend_d;
      if (uf_first) cap_q <= cap_d;
      out_q  <= out_d;
      irq_q  <= irq_d;
    end
  end

endmodule

// File: rtl/delay_pulse_timer.sv
module delay_pulse_timer
  import dpt_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_tick,
  input  logic                 ext_start,
  input  logic                 host_wr,
  input  logic [1:0]           host_addr,
  input  logic [LO_W+HI_W-1:0] host_wdata,
  output logic [LO_W+HI_W-1:0] host_rdata,
  output logic                 pulse_out,
  output logic                 irq_o
);
  localparam int W = LO_W + HI_W;

  logic [1:0]   rst_sync_q;
  logic         rst_sync_n;
  logic         en_q, irq_en_q, en_rise, host_cnt_ld, lvl_ld, lvl_val;
  logic [W-1:0] reload_q, cnt_val, seq_ld_val, cnt_ld_val;
  logic         seq_ld, seq_dec, cnt_zero, uf_first, uf_last, cnt_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  dpt_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .ext_start(ext_start), .seq_stop(uf_last),
    .cnt_val(cnt_val), .lvl_q(pulse_out),
    .en_q(en_q), .irq_en_q(irq_en_q), .reload_q(reload_q),
    .en_rise(en_rise), .host_cnt_ld(host_cnt_ld),
    .lvl_ld(lvl_ld), .lvl_val(lvl_val), .host_rdata(host_rdata)
  );

  dpt_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .tick(cnt_tick), .en_q(en_q), .en_rise(en_rise),
    .cnt_zero(cnt_zero), .reload_q(reload_q), .irq_en_q(irq_en_q),
    .lvl_ld(lvl_ld), .lvl_val(lvl_val),
    .seq_ld(seq_ld), .seq_ld_val(seq_ld_val), .seq_dec(seq_dec),
    .uf_first(uf_first), .uf_last(uf_last),
    .out_q(pulse_out), .irq_q(irq_o)
  );

  assign cnt_ld     = host_cnt_ld || seq_ld;
  assign cnt_ld_val = host_cnt_ld ? host_wdata : seq_ld_val;

  dpt_split_cnt #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .ld(cnt_ld), .ld_val(cnt_ld_val), .dec(seq_dec),
    .cnt(cnt_val), .zero(cnt_zero)
  );

endmodule

// File: rtl/delay_pulse_timer_chk.sv
module delay_pulse_timer_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         ext_start,
  input logic         host_wr,
  input logic [1:0]   host_addr,
  input logic [W-1:0] host_wdata,
  input logic         en_q,
  input logic         irq_en_q,
  input logic         uf_first,
  input logic         uf_last,
  input logic [W-1:0] cnt_val,
  input logic         pulse_out,
  input logic         irq_o
);
  logic ctrl_wr;
  assign ctrl_wr = host_wr && (host_addr == 2'd2);

  // R4
  self_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_last && !ctrl_wr) |=> !en_q);

  // R5
  out_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_first || uf_last) |=> (pulse_out != $past(pulse_out)));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(irq_en_q));

  // R7
  reload_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_first |=> (cnt_val == {W{1'b1}}));

  // R8
  stop_beats_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_last && ext_start && !ctrl_wr) |=> !en_q);

  // R9
  write_beats_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_last && ctrl_wr && host_wdata[0]) |=> en_q);

  // R10
  clear_beats_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_start && ctrl_wr && !host_wdata[0]) |=> !en_q);

  // R14
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(host_wr && host_addr == 2'd0 && !en_q)) |=> $stable(cnt_val));

endmodule

bind delay_pulse_timer delay_pulse_timer_chk #(.W(LO_W + HI_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(cnt_tick), .ext_start(ext_start),
  .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
  .en_q(en_q), .irq_en_q(irq_en_q), .uf_first(uf_first), .uf_last(uf_last),
  .cnt_val(cnt_val), .pulse_out(pulse_out), .irq_o(irq_o)
);

// File: tb/delay_pulse_timer_bench.sv
module delay_pulse_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_tick = 1'b1;
  logic         ext_start = 1'b0;
  logic         host_wr = 1'b0;
  logic [1:0]   host_addr = 2'd0;
  logic [W-1:0] host_wdata = '0;
  logic [W-1:0] host_rdata;
  logic         pulse_out, irq_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_cyc[$];
  bit exp_lvl[$];

  delay_pulse_timer u_delay_pulse_timer (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ext_start(ext_start),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .pulse_out(pulse_out), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every irq must match the next expected underflow
  always @(negedge clk) begin
    if (rst_n && irq_o) begin
      if (exp_cyc.size() == 0) begin
        chk(1'b0, "R6", "unexpected irq at cycle", cyc, 0);
      end else begin
        int ec;
        bit el;
        ec = exp_cyc.pop_front();
        el = exp_lvl.pop_front();
        chk(cyc == ec, "R2/R3", "irq cycle", cyc, ec);
        chk(pulse_out == el, "R5", "level at irq", pulse_out, el);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic run_shot(input int c, input int r, input bit lvl,
                          input bit ie, output int k0);
    logic [W-1:0] ctl;
    ctl = '0; ctl[2] = lvl; ctl[1] = ie;
    wr(2'd0, W'(c));
    wr(2'd1, W'(r));
    wr(2'd2, ctl);
    ctl[0] = 1'b1;
    wr(2'd2, ctl);
    k0 = cyc;
    if (ie) begin
      exp_cyc.push_back(k0 + c + 1);     exp_lvl.push_back(!lvl);
      exp_cyc.push_back(k0 + c + r + 2); exp_lvl.push_back(lvl);
    end
  endtask

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    chk(exp_cyc.size() == 0, req, "missing irq count", exp_cyc.size(), 0);
    exp_cyc.delete(); exp_lvl.delete();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    int k0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1", "counter", v, 0);
    rd(2'd1, v); chk(v == 0, "R1", "reload", v, 0);
    rd(2'd2, v); chk(v == 0, "R1", "control", v, 0);
    chk(!pulse_out && !irq_o, "R1", "outputs", {pulse_out, irq_o}, 0);

    // R2 R3 R4 R7 basic run
    run_shot(4, 3, 1'b0, 1'b1, k0);
    wait_to(k0 + 5);
    rd(2'd0, v); chk(v == ONES, "R7", "count after reload", v, ONES);
    @(negedge clk);
    rd(2'd0, v); chk(v == 2, "R7", "count next tick", v, 2);
    wait_to(k0 + 4 + 3 + 3);
    rd(2'd2, v); chk(v[0] == 1'b0, "R4", "enable after stop", v[0], 0);
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk(v == ONES, "R4", "count after stop", v, ONES);
    drain("R3");

    // R5 initial level high
    run_shot(10, 6, 1'b1, 1'b1, k0);
    wait_to(k0 + 10);
    chk(pulse_out == 1'b1, "R5", "level before edge", pulse_out, 1);
    wait_to(k0 + 11);
    chk(pulse_out == 1'b0, "R5", "level in pulse", pulse_out, 0);
    wait_to(k0 + 18);
    chk(pulse_out == 1'b1, "R5", "level after pulse", pulse_out, 1);
    drain("R5");

    // R6 interrupts disabled, output still toggles
    run_shot(2, 2, 1'b0, 1'b0, k0);
    wait_to(k0 + 3);
    chk(pulse_out == 1'b1, "R6", "toggle without irq", pulse_out, 1);
    wait_to(k0 + 6);
    chk(pulse_out == 1'b0, "R6", "second toggle", pulse_out, 0);
    drain("R6");

    // R13 zero reload
    run_shot(1, 0, 1'b0, 1'b1, k0);
    drain("R13");

    // R12 writes while running
    run_shot(3, 5, 1'b0, 1'b1, k0);
    wait_to(k0 + 5);
    wr(2'd1, 24'd9);
    wr(2'd0, 24'd7);
    rd(2'd1, v); chk(v == 9, "R12", "reload readback", v, 9);
    drain("R12");

    // R8 ext_start on the final underflow: stop wins
    run_shot(2, 1, 1'b0, 1'b1, k0);
    wait_to(k0 + 4);
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
    rd(2'd2, v); chk(v[0] == 1'b0, "R8", "enable after stop+start", v[0], 0);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk(v == ONES, "R8", "count frozen", v, ONES);
    drain("R8");

    // R9 enable write on the final underflow: write wins
    run_shot(2, 1, 1'b0, 1'b1, k0);
    wait_to(k0 + 4);
    wr(2'd2, 24'd3);
    rd(2'd2, v); chk(v[0] == 1'b1, "R9", "enable kept", v[0], 1);
    rd(2'd0, v); chk(v == ONES, "R9", "count at stop edge", v, ONES);
    @(negedge clk);
    rd(2'd0, v); chk(v == ONES - 1, "R9", "count continues", v, ONES - 1);
    wr(2'd2, 24'd2);
    chk(pulse_out == 1'b0, "R9", "level after run", pulse_out, 0);
    drain("R9");

    // R10 clearing write beats ext_start
    wr(2'd0, 24'h20);
    ext_start = 1'b1; host_wr = 1'b1; host_addr = 2'd2; host_wdata = '0;
    @(negedge clk);
    ext_start = 1'b0; host_wr = 1'b0;
    rd(2'd2, v); chk(v[0] == 1'b0, "R10", "enable stays clear", v[0], 0);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk(v == 24'h20, "R10", "count unchanged", v, 24'h20);

    // R8 ext_start launches an idle timer
    wr(2'd0, 24'd3);
    wr(2'd1, 24'd2);
    wr(2'd2, 24'd2);
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
    k0 = cyc;
    exp_cyc.push_back(k0 + 4); exp_lvl.push_back(1'b1);
    exp_cyc.push_back(k0 + 7); exp_lvl.push_back(1'b0);
    drain("R8");

    // R14 hold without tick, R11 borrow across halves
    cnt_tick = 1'b0;
    wr(2'd0, 24'h010000);
    wr(2'd2, 24'd1);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk(v == 24'h010000, "R14", "held without tick", v, 24'h010000);
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
    rd(2'd0, v); chk(v == 24'h00FFFF, "R11", "borrow", v, 24'h00FFFF);
    wr(2'd2, 24'd0);
    cnt_tick = 1'b1;
    drain("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule